// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block guards a shared region that at most a fixed number of holders may occupy at once. It keeps one non-negative count of free slots, loaded at reset from a parameter, and serves several requester ports. Each port can ask to enter the region (acquire) by holding a level request. It can leave the region (release) with a single-cycle pulse. An acquire is granted at once while a slot is free. Otherwise the port is parked in hardware and shows a waiting flag until a release hands it a slot.

The count is updated atomically once per cycle. All releases seen in a cycle are added first, with the sum clipped at a parameterized ceiling. At most one requester is then granted, chosen in round-robin order starting after the port granted last. When a release meets a parked requester, the slot passes straight to that requester and the count stays where it was. A requester must drop its acquire request in the cycle after its grant pulse. Dropping it earlier withdraws the wait.

Top module: `csem_unit`

## Requirements
- R1: During and right after reset the count equals INIT_COUNT (default 2), and all grant and waiting bits are 0.
- R2: An acquire seen at a clock edge while a slot is free makes that port's grant bit 1 for exactly the following cycle, and the count drops by one.
- R3: An acquire seen while the count is 0 and no release arrives gives no grant; the port's waiting bit is 1 from the next cycle for as long as the request is held.
- R4: A release in a cycle when a port is waiting grants that port in the next cycle and leaves the count unchanged.
- R5: A release with no pending acquire raises the count by one.
- R6: When several ports are pending, the grant goes to the first pending port after the most recently granted index, wrapping from the top port to port 0; after reset, port 0 ranks first.
- R7: At most one grant bit is 1 in any cycle; other pending ports stay waiting and are served in later cycles.
- R8: A release and an acquire in the same cycle at count 0 are handled release first, so the acquire is granted in the next cycle and the count remains 0.
- R9: Releases that would push the count above MAX_COUNT (default 3) leave it at MAX_COUNT and make the overflow error output 1 for the following cycle only.
- R10: A waiting port that drops its request clears its waiting bit on the next cycle and receives no grant from a later release, which instead raises the count.
- R11: The count never exceeds MAX_COUNT, and a grant is never given from a count of 0 without a release in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NUM_PORTS | Per-port acquire request, held until granted |
| rel_req | input | NUM_PORTS | Per-port release pulse, one cycle per slot returned |
| grant | output | NUM_PORTS | Per-port one-cycle grant pulse |
| waiting | output | NUM_PORTS | Per-port flag: request pending and not yet granted |
| count | output | $clog2(MAX_COUNT+1) | Current number of free slots |
| ovf_err | output | 1 | One-cycle pulse after a release was clipped at MAX_COUNT |

## Verification
The two functions that can coincide are a release and an acquire in the same cycle. When the count is 0, the order in which they are applied decides whether the acquirer is served. The bench drives a release pulse on one port on the same falling edge on which another port raises its acquire, with the count already at 0. It then expects a grant on the acquirer one cycle later and a count still at 0. The same pairing is provoked with a parked waiter, where the count must likewise stay unchanged. It is also provoked at the ceiling, where the release must be clipped and flagged even though an acquire is served in that cycle.

// File: rtl/csem_pkg.sv
package csem_pkg;

    // Kind of update applied to the slot count in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_GIVE = 2'b01,   // releases only
        OP_TAKE = 2'b10,   // grant only
        OP_BOTH = 2'b11    // releases, then a grant
    } csem_op_e;

    function automatic csem_op_e csem_classify(input logic any_rel, input logic take);
        return csem_op_e'({take, any_rel});
    endfunction

endpackage

// File: rtl/csem_rr_arb.sv
module csem_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] gnt_idx;
    logic          found;

    // Scan upward from the slot after the last winner, wrapping around
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        gnt_idx = last_q;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) gnt_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      last_q <= IW'(N - 1);
        else if (adv) last_q <= gnt_idx;
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R7

    AST_ARB_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R6

endmodule

// File: rtl/csem_counter.sv
module csem_counter
    import csem_pkg::*;
#(
    parameter int MAX_COUNT  = 3,
    parameter int INIT_COUNT = 2,
    parameter int RW         = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [RW-1:0]                  rel_cnt,
    input  logic                           take,
    output logic [$clog2(MAX_COUNT+1)-1:0] count,
    output logic                           avail_pos,
    output logic                           sat_err
);
    localparam int CW = $clog2(MAX_COUNT + 1);
    localparam int SW = CW + RW;

    logic [SW-1:0] sum;
    logic          over;
    logic [CW-1:0] avail;
    logic [CW-1:0] count_d;
    csem_op_e      op;

    // Releases are folded in before any grant, clipped at the ceiling
    always_comb begin
        sum       = SW'(count) + SW'(rel_cnt);
        over      = sum > SW'(MAX_COUNT);
        avail     = over ? CW'(MAX_COUNT) : sum[CW-1:0];
        avail_pos = avail != '0;
        op        = csem_classify(rel_cnt != '0, take);
        unique case (op)
            OP_IDLE: count_d = count;
            OP_GIVE: count_d = avail;
            OP_TAKE: count_d = count - CW'(1);
            OP_BOTH: count_d = avail - CW'(1);
            default: count_d = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= CW'(INIT_COUNT);
            sat_err <= 1'b0;
        end else begin
            count   <= count_d;
            sat_err <= over;
        end
    end

    AST_COUNT_CEIL: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAX_COUNT)); // R11

    AST_TAKE_DEC: assert property (@(posedge clk) disable iff (rst)
        (rel_cnt == '0 && take) |=> count == $past(count) - CW'(1)); // R2

    AST_HANDOFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rel_cnt == RW'(1) && take && count < CW'(MAX_COUNT)) |=> count == $past(count)); // R4

    AST_SAT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(MAX_COUNT) && rel_cnt != '0) |=> sat_err); // R9

    AST_NO_EMPTY_TAKE: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && rel_cnt == '0) |-> !take); // R11

endmodule

// File: rtl/csem_unit.sv
module csem_unit #(
    parameter int NUM_PORTS  = 4,
    parameter int INIT_COUNT = 2,
    parameter int MAX_COUNT  = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS-1:0]           acq_req,
    input  logic [NUM_PORTS-1:0]           rel_req,
    output logic [NUM_PORTS-1:0]           grant,
    output logic [NUM_PORTS-1:0]           waiting,
    output logic [$clog2(MAX_COUNT+1)-1:0] count,
    output logic                           ovf_err
);
    localparam int RW = $clog2(NUM_PORTS + 1);

    logic [NUM_PORTS-1:0] pending;
    logic [NUM_PORTS-1:0] arb_pick;
    logic [NUM_PORTS-1:0] gnt_v;
    logic [RW-1:0]        rel_cnt;
    logic                 avail_pos;
    logic                 take;

    always_comb begin
        rel_cnt = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            rel_cnt = rel_cnt + RW'(rel_req[i]);
        end
    end

    // A port just granted is expected to lower its request this cycle
    assign pending = acq_req & ~grant;
    assign gnt_v   = avail_pos ? arb_pick : '0;
    assign take    = |gnt_v;

    csem_rr_arb #(.N(NUM_PORTS)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (pending),
        .adv (take),
        .gnt (arb_pick)
    );

    csem_counter #(
        .MAX_COUNT (MAX_COUNT),
        .INIT_COUNT(INIT_COUNT),
        .RW        (RW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .rel_cnt  (rel_cnt),
        .take     (take),
        .count    (count),
        .avail_pos(avail_pos),
        .sat_err  (ovf_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant   <= '0;
            waiting <= '0;
        end else begin
            grant   <= gnt_v;
            waiting <= pending & ~gnt_v;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7

    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
        |grant |-> (($past(acq_req) & grant) == grant)); // R2

    AST_WAIT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
        |waiting |-> (($past(acq_req) & waiting) == waiting)); // R3

endmodule

// File: tb/csem_unit_bench.sv
module csem_unit_bench;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] acq_req;
    logic [NP-1:0] rel_req;
    logic [NP-1:0] grant;
    logic [NP-1:0] waiting;
    logic [1:0]    count;
    logic          ovf_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk; // 200 MHz

    csem_unit #(.NUM_PORTS(NP), .INIT_COUNT(2), .MAX_COUNT(3)) u_csem_unit (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .grant(grant), .waiting(waiting), .count(count), .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; acq_req = '0; rel_req = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", int'(count), 2);
        rst = 1'b0;
        step();
        chk("R1 count", int'(count), 2);
        chk("R1 grant", int'(grant), 0);
        chk("R1 waiting", int'(waiting), 0);
    endtask

    task automatic t_basic();
        acq_req = 4'b0001; step();
        chk("R2 grant p0", int'(grant), 1);
        chk("R2 count", int'(count), 1);
        acq_req = '0; rel_req = 4'b0001; step(); rel_req = '0;
        chk("R5 count up", int'(count), 2);
        chk("R5 no grant", int'(grant), 0);
    endtask

    task automatic t_wait();
        acq_req = 4'b0010; step(); acq_req = '0;
        chk("R2 grant p1", int'(grant), 2);
        acq_req = 4'b0100; step(); acq_req = '0;
        chk("R2 grant p2", int'(grant), 4);
        chk("R2 count zero", int'(count), 0);
        acq_req = 4'b1000; step();
        chk("R3 no grant", int'(grant), 0);
        chk("R3 waiting p3", int'(waiting), 8);
        step();
        chk("R3 still waiting", int'(waiting), 8);
        rel_req = 4'b0010; step(); rel_req = '0;
        chk("R4 handoff grant", int'(grant), 8);
        chk("R4 count held", int'(count), 0);
        chk("R4 waiting cleared", int'(waiting), 0);
        acq_req = '0;
    endtask

    task automatic t_rr();
        acq_req = 4'b0011; step();
        chk("R3 two waiting", int'(waiting), 3);
        rel_req = 4'b0100; step(); rel_req = '0;
        chk("R6 wrap to p0", int'(grant), 1);
        chk("R7 p1 still waits", int'(waiting), 2);
        acq_req = 4'b0010; rel_req = 4'b1000; step(); rel_req = '0;
        chk("R6 next p1", int'(grant), 2);
        acq_req = '0;
        acq_req = 4'b1100; step();
        chk("R3 p2 p3 waiting", int'(waiting), 12);
        rel_req = 4'b0001; step(); rel_req = '0;
        chk("R6 after p1 is p2", int'(grant), 4);
        acq_req = 4'b1000; rel_req = 4'b0010; step(); rel_req = '0;
        chk("R6 then p3", int'(grant), 8);
        chk("R4 count zero", int'(count), 0);
        acq_req = '0;
    endtask

    task automatic t_same();
        acq_req = 4'b0001; rel_req = 4'b0100; step(); rel_req = '0;
        chk("R8 acquire served", int'(grant), 1);
        chk("R8 count zero", int'(count), 0);
        chk("R8 no waiting", int'(waiting), 0);
        acq_req = '0;
    endtask

    task automatic t_cancel();
        acq_req = 4'b0010; step();
        chk("R10 waiting set", int'(waiting), 2);
        acq_req = '0; step();
        chk("R10 waiting cleared", int'(waiting), 0);
        rel_req = 4'b1000; step(); rel_req = '0;
        chk("R10 no grant", int'(grant), 0);
        chk("R10 count up", int'(count), 1);
    endtask

    task automatic t_sat();
        rel_req = 4'b0001; step();
        chk("R5 count 2", int'(count), 2);
        step();
        chk("R5 count 3", int'(count), 3);
        chk("R9 no err yet", int'(ovf_err), 0);
        step(); rel_req = '0;
        chk("R9 count clipped", int'(count), 3);
        chk("R9 err pulse", int'(ovf_err), 1);
        step();
        chk("R9 err drops", int'(ovf_err), 0);
    endtask

    task automatic t_multi();
        acq_req = 4'b0110; step();
        chk("R7 single grant p1", int'(grant), 2);
        chk("R7 p2 waits", int'(waiting), 4);
        chk("R2 count 2", int'(count), 2);
        acq_req = 4'b0100; step(); acq_req = '0;
        chk("R7 then p2", int'(grant), 4);
        chk("R2 count 1", int'(count), 1);
        step();
        chk("R7 quiet", int'(grant), 0);
        rel_req = 4'b1001; step(); rel_req = '0;
        chk("R5 two releases", int'(count), 3);
        chk("R9 fits, no err", int'(ovf_err), 0);
        rel_req = 4'b0011; step(); rel_req = '0;
        chk("R11 clipped at max", int'(count), 3);
        chk("R9 multi err", int'(ovf_err), 1);
        acq_req = 4'b0001; rel_req = 4'b0010; step(); rel_req = '0; acq_req = '0;
        chk("R9 err with grant", int'(ovf_err), 1);
        chk("R8 grant at ceiling", int'(grant), 1);
        chk("R11 count after", int'(count), 2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wait();
        t_rr();
        t_same();
        t_cancel();
        t_sat();
        t_multi();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule